// File: doc/BRIEF.md
# SPI Serial EEPROM Target

This block is the target side of a 512-byte serial EEPROM reached over SPI mode 0. A host selects it with an active-low select, clocks an 8-bit opcode in on the serial input, and then, depending on the opcode, supplies an address, reads a stream of array bytes or the status byte, or sends data bytes to be written. The ninth address bit travels inside the opcode, and a second byte carries the lower eight.

The block owns the write-enable latch, the two protection bits and a 512x8 array that serves reads. It does not program the array on its own. Each complete data byte of a write is handed out on a byte port together with its page-wrapped address. A commit pulse tells a separate page-write controller to start a write cycle. That controller reports the cycle through `wip` and writes the array back through the array write port.

All serial pins are sampled by the system clock `clk`. Edges of `sck` are found by comparing `sck` with its value one clock earlier, so `sck` must be much slower than `clk`.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset `so_oe` is low, no byte or commit pulse is issued, and the status byte reads 0x00 while `wip` is low.
- R2: Opcode 0000_A011 is a read and 0000_A010 is a write. Bit 3 (A) is address bit 8, and the next byte gives bits 7:0. Read data is shifted out MSB first, and `so` changes one `clk` after a falling `sck` edge.
- R3: During a read, each completed byte advances the address by one, and the address wraps from 0x1FF to 0x000.
- R4: Opcode 0x06 sets the write-enable latch only when `cs_n` rises after all eight opcode bits. Any bytes that follow in the same selection are ignored, so a write placed there issues no byte and no commit.
- R5: Each complete data byte of a write appears for one `clk` on `wr_byte_*`. Its address keeps bits 8:4 and wraps bits 3:0 within the 16-byte page.
- R6: `wr_commit` pulses only when `cs_n` rises exactly at a byte boundary after at least one data byte, with the latch set, `wp_n` high and `wip` low.
- R7: Opcode 0x05 returns the status byte repeatedly. Bit 0 is `wip`, bit 1 is the latch, and bits 3:2 are the protection bits. It stays readable while `wip` is high. An array read begun while `wip` is high is refused, and `so_oe` stays low.
- R8: The latch is cleared by opcode 0x04 and when `wip` falls.
- R9: Opcode 0x01 followed by a byte loads that byte's bits 3:2 into the protection bits and clears the latch. This happens at the `cs_n` rise, and only if the latch is set, `wp_n` is high and `wip` is low. Otherwise the opcode has no effect.
- R10: While `hold_n` is low, `sck` edges are ignored and the transfer state is kept. The transfer resumes from the same bit when `hold_n` returns high.
- R11: Any other opcode is ignored until `cs_n` next rises, and `so_oe` stays low.
- R12: `so_oe` is low whenever `cs_n` is high or `hold_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Active-low pause |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for `so` |
| wr_byte_vld | output | 1 | One-clock strobe for a received write byte |
| wr_byte_addr | output | 9 | Page-wrapped address of the write byte |
| wr_byte_data | output | 8 | Received write byte |
| wr_commit | output | 1 | One-clock pulse that starts a write cycle |
| wip | input | 1 | Write cycle in progress, from the page controller |
| arr_we | input | 1 | Array write strobe from the page controller |
| arr_addr | input | 9 | Array write address |
| arr_wdata | input | 8 | Array write data |

## Verification
The assertions assume that every serial pin is synchronous to `clk` and that each `sck` level lasts at least one `clk`. They also assume `wip` rises only after a commit and falls once the page controller has finished. The bench moves `sck`, `si`, `cs_n` and `hold_n` only on falling `clk` edges and holds each `sck` level for at least one full clock. It plays the page controller itself: it raises `wip` after a commit, writes the array through the array write port, then drops `wip`. `hold_n` is released only while `sck` is high, so the next falling edge is still seen.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int PAGE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       hold_n,
  input  logic       wp_n,
  output logic       so,
  output logic       so_oe,
  output logic       wr_byte_vld,
  output logic [8:0] wr_byte_addr,
  output logic [7:0] wr_byte_data,
  output logic       wr_commit,
  input  logic       wip,
  input  logic       arr_we,
  input  logic [8:0] arr_addr,
  input  logic [7:0] arr_wdata
);
  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {P_CMD, P_ADDR, P_RDAT, P_WDAT, P_RDSR, P_WRSR, P_WREN, P_IGN} phase_t;

  logic [7:0]    mem [DEPTH];
  phase_t        phase;
  logic          sck_q, cs_q, wip_q, so_q;
  logic [2:0]    cnt;
  logic [6:0]    sh;
  logic          is_rd, a8, wel, wgot, wrsr_got;
  logic [AW-1:0] ptr;
  logic [7:0]    obyte;
  logic [1:0]    bp, wrsr_val;

  wire       act     = !cs_n && hold_n;
  wire       rise    = act && sck && !sck_q;
  wire       fall    = act && !sck && sck_q;
  wire       cs_rise = cs_n && !cs_q;
  wire [7:0] nxt     = {sh, si};
  wire [7:0] status  = {4'b0, bp, wel, wip};
  wire       talking = (phase == P_RDAT) || (phase == P_RDSR);

  assign so    = so_q;
  assign so_oe = act && talking;

  always_ff @(posedge clk) begin
    if (arr_we) mem[arr_addr] <= arr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_CMD; sck_q <= 1'b0; cs_q <= 1'b1; wip_q <= 1'b0; so_q <= 1'b0;
      cnt <= '0; sh <= '0; is_rd <= 1'b0; a8 <= 1'b0; wel <= 1'b0; wgot <= 1'b0;
      wrsr_got <= 1'b0; ptr <= '0; obyte <= '0; bp <= '0; wrsr_val <= '0;
      wr_byte_vld <= 1'b0; wr_byte_addr <= '0; wr_byte_data <= '0; wr_commit <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q <= cs_n;
      wip_q <= wip;
      wr_byte_vld <= 1'b0;
      wr_commit <= 1'b0;
      if (wip_q && !wip) wel <= 1'b0;
      if (cs_n) begin
        phase <= P_CMD; cnt <= '0; wgot <= 1'b0; wrsr_got <= 1'b0;
      end
      if (cs_rise) begin
        if (phase == P_WREN) wel <= 1'b1;
        if (phase == P_WDAT && cnt == 3'd0 && wgot && wel && wp_n && !wip) wr_commit <= 1'b1;
        if (wrsr_got && wel && wp_n && !wip) begin
          bp <= wrsr_val;
          wel <= 1'b0;
        end
      end
      if (fall && talking) so_q <= obyte[3'd7 - cnt];
      if (rise) begin
        sh <= nxt[6:0];
        cnt <= cnt + 3'd1;
        if (cnt == 3'd7) begin
          case (phase)
            P_CMD: begin
              if (nxt[7:4] == 4'h0 && nxt[2:1] == 2'b01) begin
                phase <= P_ADDR; is_rd <= nxt[0]; a8 <= nxt[3];
              end else if (nxt == 8'h06) phase <= P_WREN;
              else if (nxt == 8'h04) begin wel <= 1'b0; phase <= P_IGN; end
              else if (nxt == 8'h05) begin phase <= P_RDSR; obyte <= status; end
              else if (nxt == 8'h01) phase <= P_WRSR;
              else phase <= P_IGN;
            end
            P_ADDR: begin
              if (!is_rd) begin
                phase <= P_WDAT; ptr <= {a8, nxt};
              end else if (wip) phase <= P_IGN;
              else begin
                phase <= P_RDAT; obyte <= mem[{a8, nxt}]; ptr <= {a8, nxt} + 9'd1;
              end
            end
            P_RDAT: begin obyte <= mem[ptr]; ptr <= ptr + 9'd1; end
            P_WDAT: begin
              wr_byte_vld <= 1'b1; wr_byte_addr <= ptr; wr_byte_data <= nxt; wgot <= 1'b1;
              ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
            end
            P_RDSR: obyte <= status;
            P_WRSR: begin wrsr_val <= nxt[3:2]; wrsr_got <= 1'b1; phase <= P_IGN; end
            default: ;
          endcase
        end
      end
    end
  end

  // R4
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_n) && $past(phase) == P_WREN);
  // R6
  commit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(wel) && $past(wp_n) && !$past(wip));
  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n && !cs_n) |=> $stable(cnt) && $stable(ptr) && $stable(phase));
  // R7
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_RDAT && $past(phase) == P_ADDR) |-> !$past(wip));
  // R5
  page_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_WDAT && $past(phase) == P_WDAT) |-> ptr[AW-1:PAGE_W] == $past(ptr[AW-1:PAGE_W]));
endmodule

// File: tb/spi_eeprom_slave_bench.sv
module spi_eeprom_slave_bench;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, hold_n = 1, wp_n = 1;
  logic wip = 0, arr_we = 0;
  logic [8:0] arr_addr = '0;
  logic [7:0] arr_wdata = '0;
  logic so, so_oe, wr_byte_vld, wr_commit;
  logic [8:0] wr_byte_addr;
  logic [7:0] wr_byte_data;

  int checks = 0, fails = 0, ncommit = 0;
  bit done = 0;
  logic oe_acc = 0;
  logic [8:0] got_a[$];
  logic [7:0] got_d[$];
  logic [7:0] ref_mem [512];
  logic ref_wel = 0;
  logic [1:0] ref_bp = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_eeprom_slave u_spi_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n), .wp_n(wp_n),
    .so(so), .so_oe(so_oe), .wr_byte_vld(wr_byte_vld), .wr_byte_addr(wr_byte_addr),
    .wr_byte_data(wr_byte_data), .wr_commit(wr_commit), .wip(wip), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata));

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (wr_byte_vld) begin got_a.push_back(wr_byte_addr); got_d.push_back(wr_byte_data); end
    if (wr_commit) ncommit++;
    if (rst_n && (cs_n || !hold_n)) begin
      checks++;
      if (so_oe) begin fails++; $display("FAIL R12 actual=1 expected=0"); end
    end
  end

  task automatic sbit(input logic b, output logic r);
    @(negedge clk); sck = 0; si = b;
    @(negedge clk); r = so; oe_acc = oe_acc | so_oe; sck = 1;
    @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      logic rb;
      sbit(t[i], rb);
      r[i] = rb;
    end
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 0; oe_acc = 0;
    @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk); sck = 0; cs_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, r); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
  endtask

  task automatic aload(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk); arr_we = 1; arr_addr = a; arr_wdata = d;
    @(negedge clk); arr_we = 0;
    ref_mem[a] = d;
  endtask

  function automatic logic [7:0] exp_status();
    return {4'b0, ref_bp, ref_wel, wip};
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, s;
    logic [8:0] a;
    int c0;
    for (int i = 0; i < 512; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 oe", so_oe, 0);
    chk("R1 commit", wr_commit, 0);
    rdsr(s); chk("R1 status", s, 8'h00);

    for (int i = 0; i < 4; i++) begin
      a = 9'h1FC + 9'(i); aload(a, a[7:0] ^ 8'h5A);
      a = 9'(i);          aload(a, a[7:0] ^ 8'h5A);
    end

    // R2 R3: read with A8=1 crossing the top of the array
    sel(); xfer(8'h0B, r); xfer(8'hFD, r);
    for (int i = 0; i < 5; i++) begin
      a = 9'h1FD + 9'(i);
      xfer(8'h00, r); chk("R3 wrap read", r, ref_mem[a]);
    end
    desel();
    chk("R2 oe during read", oe_acc, 1);
    sel(); xfer(8'h03, r); xfer(8'h01, r); xfer(8'h00, r); desel();
    chk("R2 read A8=0", r, ref_mem[1]);

    // R4: write in the same selection as the enable
    got_a.delete(); got_d.delete(); c0 = ncommit;
    sel(); xfer(8'h06, r); xfer(8'h02, r); xfer(8'h10, r); xfer(8'hAA, r); desel();
    chk("R4 no commit", ncommit - c0, 0);
    chk("R4 no bytes", got_a.size(), 0);
    ref_wel = 1;
    rdsr(s); chk("R4 latch set", s, exp_status());

    // R5 R6: page wrap write
    got_a.delete(); got_d.delete(); c0 = ncommit;
    sel(); xfer(8'h0A, r); xfer(8'hFE, r); xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); desel();
    chk("R5 count", got_a.size(), 3);
    if (got_a.size() == 3) begin
      chk("R5 a0", got_a[0], 9'h1FE); chk("R5 d0", got_d[0], 8'h11);
      chk("R5 a1", got_a[1], 9'h1FF); chk("R5 d1", got_d[1], 8'h22);
      chk("R5 a2", got_a[2], 9'h1F0); chk("R5 d2", got_d[2], 8'h33);
    end
    chk("R6 commit", ncommit - c0, 1);

    // R7: status during write cycle, array read refused
    @(negedge clk); wip = 1;
    rdsr(s); chk("R7 status busy", s, exp_status());
    sel(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h00, r); desel();
    chk("R7 read refused", oe_acc, 0);
    for (int i = 0; i < 3; i++) aload(got_a[i], got_d[i]);
    @(negedge clk); wip = 0; ref_wel = 0;
    @(negedge clk);
    rdsr(s); chk("R8 cleared by wip fall", s, exp_status());
    sel(); xfer(8'h0B, r); xfer(8'hF0, r); xfer(8'h00, r); desel();
    chk("R7 read back", r, 8'h33);

    // R6: write with latch clear
    got_a.delete(); got_d.delete(); c0 = ncommit;
    sel(); xfer(8'h02, r); xfer(8'h20, r); xfer(8'h44, r); desel();
    chk("R6 no latch", ncommit - c0, 0);
    // R6: write protect low
    cmd1(8'h06); ref_wel = 1;
    @(negedge clk); wp_n = 0;
    sel(); xfer(8'h02, r); xfer(8'h20, r); xfer(8'h44, r); desel();
    @(negedge clk); wp_n = 1;
    chk("R6 wp low", ncommit - c0, 0);
    // R6: select raised mid-byte
    sel(); xfer(8'h02, r); xfer(8'h30, r); xfer(8'h55, r);
    for (int i = 0; i < 4; i++) begin logic rb; sbit(1'b1, rb); end
    desel();
    chk("R6 mid byte", ncommit - c0, 0);
    rdsr(s); chk("R6 latch kept", s, exp_status());

    // R8: write-disable
    cmd1(8'h04); ref_wel = 0;
    rdsr(s); chk("R8 disable", s, exp_status());

    // R9: status write
    sel(); xfer(8'h01, r); xfer(8'h0C, r); desel();
    rdsr(s); chk("R9 no latch", s, exp_status());
    cmd1(8'h06);
    sel(); xfer(8'h01, r); xfer(8'h0C, r); desel();
    ref_bp = 2'b11; ref_wel = 0;
    rdsr(s); chk("R9 bp set", s, exp_status());

    // R10: hold in mid-byte
    sel(); xfer(8'h03, r); xfer(8'h00, r);
    for (int i = 7; i >= 4; i--) begin logic rb; sbit(1'b0, rb); r[i] = rb; end
    @(negedge clk); hold_n = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sck = 0;
      @(negedge clk); sck = 1;
    end
    chk("R10 oe in hold", so_oe, 0);
    @(negedge clk); hold_n = 1;
    for (int i = 3; i >= 0; i--) begin logic rb; sbit(1'b0, rb); r[i] = rb; end
    chk("R10 byte resumes", r, ref_mem[0]);
    xfer(8'h00, r); chk("R10 next byte", r, ref_mem[1]);
    desel();

    // R11: unknown opcode
    got_a.delete(); got_d.delete();
    sel(); xfer(8'hFF, r); xfer(8'h0C, r); xfer(8'h00, r); desel();
    chk("R11 oe", oe_acc, 0);
    chk("R11 no bytes", got_a.size(), 0);
    rdsr(s); chk("R11 status", s, exp_status());

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule